// File: doc/BRIEF.md
# Multi-Lane I2S Audio Transmitter

This block turns parallel PCM samples into I2S-format serial audio. From the system clock it makes its own master clock, bit clock and word-select (frame sync), so the external audio DAC needs no clock source of its own. Four serial data lanes share the one bit clock and the one word-select. In stereo mode only lane 0 carries audio. In multichannel mode all four lanes carry left/right pairs side by side, which gives eight channels per frame.

Software or an upstream engine places one frame's samples on a wide parallel word and raises a valid strobe. A one-entry holding register takes the word whenever it is empty. At each frame boundary the held word moves into the serializer. If the holding register is empty at that point, the previous frame is sent again and a sticky underrun flag is raised. The slot width (16, 24 or 32 bits) and the lane mode are taken up only at a frame boundary.

Top module: `i2s_multilane_tx`

## Requirements
- R1: While `rst_n` is low and before the first bit-clock falling edge, `mclk_o` and `bclk_o` are 0, `lrclk_o` is 1, every `sd_o` lane is 0, `smp_ready` is 1 and `underrun` is 0.
- R2: `mclk_o` has a period of 2*`mclk_half` system clocks. A `mclk_half` of 0 behaves as 1.
- R3: `bclk_o` has a period of 2*`bclk_half` master-clock periods (0 behaves as 1), and each `bclk_o` edge coincides with a rising edge of `mclk_o`.
- R4: `lrclk_o` and `sd_o` change only in the cycle where `bclk_o` falls. `lrclk_o` low marks the left channel. Each channel word is sent MSB first, and its MSB appears one bit clock after the `lrclk_o` edge.
- R5: `slot_sel` encodes the bits per channel: 0 = 16, 1 = 24, 2 or 3 = 32. A frame lasts twice that many bit clocks.
- R6: A `SAMPLE_W`-bit sample (default 24) is left-justified into its slot. Slot bits below the sample are sent as 0, and a narrower slot sends only the sample's top bits.
- R7: `smp_data` holds lane i's left sample at bits [(2i)*SAMPLE_W +: SAMPLE_W] and its right sample at [(2i+1)*SAMPLE_W +: SAMPLE_W]. A word is taken on a cycle with `smp_valid` and `smp_ready` both high. `smp_ready` stays low while a word waits for the next frame, and one word is used per frame.
- R8: With `multi_mode` = 0, only lane 0 carries audio. Lanes 1 to 3 send zeros and their input fields are ignored.
- R9: With `multi_mode` = 1, lane i sends its own left/right pair in parallel with the other lanes, under the shared clock and word-select.
- R10: If no word is waiting at a frame boundary, the previous frame's samples are sent again and `underrun` goes to 1. It stays at 1 until `underrun_clr` is sampled high; a new underrun in the same cycle wins.
- R11: A change of `slot_sel` or `multi_mode` during a frame does not touch that frame. It applies from the next frame on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mclk_half | input | DIV_W | Master-clock half period in system clocks |
| bclk_half | input | DIV_W | Bit-clock half period in master-clock periods |
| multi_mode | input | 1 | 0 = stereo on lane 0, 1 = four lanes |
| slot_sel | input | 2 | Bits per channel select |
| smp_valid | input | 1 | Frame word offered |
| smp_ready | output | 1 | Holding register empty |
| smp_data | input | LANES*2*SAMPLE_W | Packed left/right samples of all lanes |
| underrun_clr | input | 1 | Clears the underrun flag |
| underrun | output | 1 | Sticky underrun flag |
| mclk_o | output | 1 | Master clock for the DAC |
| bclk_o | output | 1 | Bit clock |
| lrclk_o | output | 1 | Word-select, low = left |
| sd_o | output | LANES | Serial data lanes |

## Verification
The hardest situation to reach is a change of slot width and lane mode that lands in the middle of a frame while another word is already waiting. This is where a frame could be cut short or sent in a mixed format. The stimulus keeps the holding register full in multichannel 24-bit mode. Right after the second frame starts, it switches to 16-bit stereo, and an I2S decoder in the bench then confirms that this frame keeps its 24-bit, four-lane shape and that the next frame has the new one. Underrun is reached by simply stopping the feed. The repeated frame and the flag are then checked together.

// File: rtl/i2s_tx_pkg.sv
package i2s_tx_pkg;

  localparam int SLOT_MAX = 32;
  localparam int POS_W    = $clog2(2 * SLOT_MAX);
  localparam int K_W      = POS_W - 1;

  typedef enum logic [1:0] {
    SLOT_16     = 2'd0,
    SLOT_24     = 2'd1,
    SLOT_32     = 2'd2,
    SLOT_32_ALT = 2'd3
  } slot_sel_e;

  // Bits per channel for a slot selection code.
  function automatic logic [POS_W-1:0] slot_len(input logic [1:0] sel);
    case (slot_sel_e'(sel))
      SLOT_16: return POS_W'(16);
      SLOT_24: return POS_W'(24);
      default: return POS_W'(32);
    endcase
  endfunction

endpackage

// File: rtl/i2s_clkgen.sv
module i2s_clkgen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] mclk_half,
  input  logic [DIV_W-1:0] bclk_half,
  output logic             mclk_o,
  output logic             bclk_o,
  output logic             bclk_fall_tick
);

  function automatic logic [DIV_W-1:0] eff_limit(input logic [DIV_W-1:0] v);
    return (v == '0) ? DIV_W'(1) : v;
  endfunction

  logic [DIV_W-1:0] mcnt_q, bcnt_q;
  logic             mclk_q, bclk_q;
  logic             mclk_toggle, mclk_rise_tick, bclk_toggle;

  assign mclk_toggle    = (mcnt_q >= eff_limit(mclk_half) - DIV_W'(1));
  assign mclk_rise_tick = mclk_toggle && !mclk_q;
  assign bclk_toggle    = mclk_rise_tick && (bcnt_q >= eff_limit(bclk_half) - DIV_W'(1));
  assign bclk_fall_tick = bclk_toggle && bclk_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mcnt_q <= '0;
      bcnt_q <= '0;
      mclk_q <= 1'b0;
      bclk_q <= 1'b0;
    end else begin
      mcnt_q <= mclk_toggle ? '0 : mcnt_q + DIV_W'(1);
      if (mclk_toggle) mclk_q <= !mclk_q;
      if (mclk_rise_tick) bcnt_q <= bclk_toggle ? '0 : bcnt_q + DIV_W'(1);
      if (bclk_toggle) bclk_q <= !bclk_q;
    end
  end

  assign mclk_o = mclk_q;
  assign bclk_o = bclk_q;

  AST_BCLK_ON_MCLK_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(bclk_q) |-> $rose(mclk_q)); // R3

endmodule

// File: rtl/i2s_frame_ctrl.sv
module i2s_frame_ctrl
  import i2s_tx_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           fall_tick,
  input  logic [1:0]     slot_sel,
  input  logic           multi_req,
  output logic           frame_start,
  output logic           multi_eff,
  output logic           ch_right,
  output logic [K_W-1:0] bit_k,
  output logic           lrclk_o
);

  logic [POS_W-1:0] pos_q, len_q, len_eff;
  logic             multi_q, lr_q;
  logic [POS_W:0]   frame_last;
  logic             at_start;

  assign at_start    = (pos_q == '0);
  assign frame_start = fall_tick && at_start;
  // Configuration is looked at only where a new frame begins.
  assign len_eff     = at_start ? slot_len(slot_sel) : len_q;
  assign multi_eff   = at_start ? multi_req : multi_q;
  assign ch_right    = (pos_q >= len_eff);
  assign bit_k       = K_W'(ch_right ? pos_q - len_eff : pos_q);
  assign frame_last  = {len_eff, 1'b0} - (POS_W+1)'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos_q   <= '0;
      len_q   <= slot_len(2'd2);
      multi_q <= 1'b0;
      lr_q    <= 1'b1;
    end else if (fall_tick) begin
      lr_q  <= ch_right;
      pos_q <= ({1'b0, pos_q} == frame_last) ? '0 : pos_q + POS_W'(1);
      if (at_start) begin
        len_q   <= len_eff;
        multi_q <= multi_req;
      end
    end
  end

  assign lrclk_o = lr_q;

  AST_LR_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(lr_q) |-> $past(fall_tick)); // R4
  AST_CFG_FRAME_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> ($stable(len_q) && $stable(multi_q))); // R11
  AST_POS_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> ({1'b0, pos_q} < {len_q, 1'b0})); // R5

endmodule

// File: rtl/i2s_sample_buf.sv
module i2s_sample_buf #(
  parameter int DATA_W = 192
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  input  logic              frame_start,
  input  logic              clr,
  output logic [DATA_W-1:0] cur_view,
  output logic              underrun
);

  logic [DATA_W-1:0] hold_q, cur_q;
  logic              full_q, urun_q;
  logic              accept, swap, starve;

  assign in_ready = !full_q;
  assign accept   = in_valid && !full_q;
  assign swap     = frame_start && full_q;
  assign starve   = frame_start && !full_q;
  // The new frame's first bit must come from the word being promoted.
  assign cur_view = swap ? hold_q : cur_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q <= '0;
      cur_q  <= '0;
      full_q <= 1'b0;
      urun_q <= 1'b0;
    end else begin
      if (accept) hold_q <= in_data;
      if (swap) cur_q <= hold_q;
      if (accept) full_q <= 1'b1;
      else if (swap) full_q <= 1'b0;
      if (starve) urun_q <= 1'b1;
      else if (clr) urun_q <= 1'b0;
    end
  end

  assign underrun = urun_q;

  AST_HOLD_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (full_q && !frame_start) |=> ($stable(hold_q) && full_q)); // R7
  AST_UNDERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (urun_q && !clr) |=> urun_q); // R10
  AST_REPEAT_ON_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    starve |=> ($stable(cur_q) && urun_q)); // R10

endmodule

// File: rtl/i2s_lane_ser.sv
module i2s_lane_ser
  import i2s_tx_pkg::*;
#(
  parameter int SAMPLE_W = 24
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                fall_tick,
  input  logic                lane_on,
  input  logic                ch_right,
  input  logic [K_W-1:0]      bit_k,
  input  logic [SAMPLE_W-1:0] left_smp,
  input  logic [SAMPLE_W-1:0] right_smp,
  output logic                sd_o
);

  // Slot bit k counted from the MSB; zero below the sample's LSB.
  function automatic logic pick_bit(input logic [SAMPLE_W-1:0] s,
                                    input logic [K_W-1:0] k);
    logic [SAMPLE_W-1:0] t;
    t = s << k;
    return (int'(k) < SAMPLE_W) ? t[SAMPLE_W-1] : 1'b0;
  endfunction

  logic pend_q, sd_q, nxt_bit;

  assign nxt_bit = lane_on && pick_bit(ch_right ? right_smp : left_smp, bit_k);

  // One stage of delay puts the MSB one bit clock after word-select.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      sd_q   <= 1'b0;
    end else if (fall_tick) begin
      sd_q   <= pend_q;
      pend_q <= nxt_bit;
    end
  end

  assign sd_o = sd_q;

  AST_OFF_LANE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (fall_tick && !lane_on) |=> !pend_q); // R8
  AST_SD_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sd_q) |-> $past(fall_tick)); // R4

endmodule

// File: rtl/i2s_multilane_tx.sv
module i2s_multilane_tx
  import i2s_tx_pkg::*;
#(
  parameter int LANES    = 4,
  parameter int SAMPLE_W = 24,
  parameter int DIV_W    = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [DIV_W-1:0]            mclk_half,
  input  logic [DIV_W-1:0]            bclk_half,
  input  logic                        multi_mode,
  input  logic [1:0]                  slot_sel,
  input  logic                        smp_valid,
  output logic                        smp_ready,
  input  logic [LANES*2*SAMPLE_W-1:0] smp_data,
  input  logic                        underrun_clr,
  output logic                        underrun,
  output logic                        mclk_o,
  output logic                        bclk_o,
  output logic                        lrclk_o,
  output logic [LANES-1:0]            sd_o
);

  localparam int FRAME_W = LANES * 2 * SAMPLE_W;

  logic               fall_tick, frame_start, multi_eff, ch_right;
  logic [K_W-1:0]     bit_k;
  logic [FRAME_W-1:0] cur_view;

  i2s_clkgen #(.DIV_W(DIV_W)) u_clk (
    .clk(clk), .rst_n(rst_n), .mclk_half(mclk_half), .bclk_half(bclk_half),
    .mclk_o(mclk_o), .bclk_o(bclk_o), .bclk_fall_tick(fall_tick)
  );

  i2s_frame_ctrl u_frm (
    .clk(clk), .rst_n(rst_n), .fall_tick(fall_tick), .slot_sel(slot_sel),
    .multi_req(multi_mode), .frame_start(frame_start), .multi_eff(multi_eff),
    .ch_right(ch_right), .bit_k(bit_k), .lrclk_o(lrclk_o)
  );

  i2s_sample_buf #(.DATA_W(FRAME_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .in_valid(smp_valid), .in_data(smp_data),
    .in_ready(smp_ready), .frame_start(frame_start), .clr(underrun_clr),
    .cur_view(cur_view), .underrun(underrun)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic lane_on;
    if (g == 0) begin : g_main
      assign lane_on = 1'b1;
    end else begin : g_extra
      assign lane_on = multi_eff;
    end
    i2s_lane_ser #(.SAMPLE_W(SAMPLE_W)) u_ser (
      .clk(clk), .rst_n(rst_n), .fall_tick(fall_tick), .lane_on(lane_on),
      .ch_right(ch_right), .bit_k(bit_k),
      .left_smp(cur_view[(2*g)*SAMPLE_W +: SAMPLE_W]),
      .right_smp(cur_view[(2*g+1)*SAMPLE_W +: SAMPLE_W]),
      .sd_o(sd_o[g])
    );
  end

  AST_READY_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && smp_ready) |=> !smp_ready); // R7

endmodule

// File: tb/sim_i2s_multilane_tx.sv
`timescale 1ns/1ps
module sim_i2s_multilane_tx;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n = 1'b0;
  logic [7:0]  mclk_half = 8'd1, bclk_half = 8'd1;
  logic        multi_mode = 1'b0;
  logic [1:0]  slot_sel = 2'd0;
  logic        smp_valid = 1'b0;
  logic        smp_ready;
  logic [191:0] smp_data = '0;
  logic        underrun_clr = 1'b0;
  logic        underrun, mclk_o, bclk_o, lrclk_o;
  logic [3:0]  sd_o;

  i2s_multilane_tx u0 (
    .clk(clk), .rst_n(rst_n), .mclk_half(mclk_half), .bclk_half(bclk_half),
    .multi_mode(multi_mode), .slot_sel(slot_sel), .smp_valid(smp_valid),
    .smp_ready(smp_ready), .smp_data(smp_data), .underrun_clr(underrun_clr),
    .underrun(underrun), .mclk_o(mclk_o), .bclk_o(bclk_o), .lrclk_o(lrclk_o),
    .sd_o(sd_o)
  );

  int checks = 0, fails = 0;

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [23:0] smp(input int f, input int l, input int c);
    return 24'((f + 1) * 24'h1357B + l * 24'h20406 + c * 24'h0F0F0F + 24'h800001);
  endfunction

  function automatic logic [191:0] mk(input int f);
    logic [191:0] d;
    for (int l = 0; l < 4; l++)
      for (int c = 0; c < 2; c++) d[(2*l+c)*24 +: 24] = smp(f, l, c);
    return d;
  endfunction

  function automatic logic [31:0] exp_word(input logic [23:0] s, input int slot);
    logic [31:0] w;
    w = {8'h00, s};
    return (slot >= 24) ? (w << (slot - 24)) : (w >> (24 - slot));
  endfunction

  // I2S decoder and edge monitors
  logic        dec_clr = 1'b1;
  logic        prev_b = 1'b0, last_lr = 1'b1, last_m = 1'b0, prev_rst = 1'b0, rise_lr = 1'b1;
  logic [3:0]  last_sd = '0;
  logic [31:0] acc [0:3];
  logic [31:0] lw  [0:3];
  logic [31:0] fl  [0:63][0:3];
  logic [31:0] fr  [0:63][0:3];
  int          fwl [0:63];
  int          fwr [0:63];
  int          cnt = 0, lwid = 0, fc = 0, fmt_err = 0, align_err = 0;
  logic        left_ok = 1'b0;

  always @(negedge clk) begin
    if (dec_clr) begin
      fc = 0; cnt = 0; left_ok = 1'b0; rise_lr = 1'b1;
      for (int l = 0; l < 4; l++) acc[l] = '0;
    end else begin
      if (rst_n && prev_rst) begin
        if ((lrclk_o !== last_lr || sd_o !== last_sd) && !(prev_b && !bclk_o)) fmt_err++;
        if ((bclk_o !== prev_b) && !(mclk_o && !last_m)) align_err++;
      end
      if (!prev_b && bclk_o) begin
        for (int l = 0; l < 4; l++) acc[l] = {acc[l][30:0], sd_o[l]};
        cnt++;
        if (lrclk_o != rise_lr) begin
          if (rise_lr == 1'b0) begin
            for (int l = 0; l < 4; l++) lw[l] = acc[l];
            lwid = cnt; left_ok = 1'b1;
          end else if (left_ok && fc < 64) begin
            for (int l = 0; l < 4; l++) begin fl[fc][l] = lw[l]; fr[fc][l] = acc[l]; end
            fwl[fc] = lwid; fwr[fc] = cnt; fc++; left_ok = 1'b0;
          end
          for (int l = 0; l < 4; l++) acc[l] = '0;
          cnt = 0;
        end
        rise_lr = lrclk_o;
      end
    end
    prev_b = bclk_o; last_lr = lrclk_o; last_sd = sd_o; last_m = mclk_o; prev_rst = rst_n;
  end

  task automatic do_reset(input logic [7:0] mh, input logic [7:0] bh, input logic mm,
                          input logic [1:0] ss, input bit preload);
    @(negedge clk);
    rst_n = 1'b0; dec_clr = 1'b1; smp_valid = 1'b0; underrun_clr = 1'b0;
    mclk_half = mh; bclk_half = bh; multi_mode = mm; slot_sel = ss;
    repeat (3) @(negedge clk);
    if (preload) begin smp_data = mk(0); smp_valid = 1'b1; end
    rst_n = 1'b1; dec_clr = 1'b0;
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  task automatic push(input int f);
    @(negedge clk);
    smp_data = mk(f); smp_valid = 1'b1;
    while (!smp_ready) @(negedge clk);
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  task automatic wait_fc(input int n);
    int t = 0;
    while (fc < n && t < 20000) begin @(negedge clk); t++; end
    if (fc < n) chk("frame count timeout", fc, n);
  endtask

  task automatic meas(input bit use_b, output int cyc);
    logic p, s;
    cyc = 0;
    p = use_b ? bclk_o : mclk_o;
    for (int t = 0; t < 2000; t++) begin
      @(negedge clk); s = use_b ? bclk_o : mclk_o;
      if (!p && s) break;
      p = s;
    end
    p = 1'b1;
    for (int t = 0; t < 2000; t++) begin
      @(negedge clk); cyc++; s = use_b ? bclk_o : mclk_o;
      if (!p && s) break;
      p = s;
    end
  endtask

  task automatic chk_frame(input string tag, input int idx, input int src,
                           input int slot, input bit mm);
    chk({tag, " left width"}, fwl[idx], slot);
    chk({tag, " right width"}, fwr[idx], slot);
    for (int l = 0; l < 4; l++) begin
      chk($sformatf("%s frame%0d lane%0d left", tag, idx, l), fl[idx][l],
          (l == 0 || mm) ? exp_word(smp(src, l, 0), slot) : 32'h0);
      chk($sformatf("%s frame%0d lane%0d right", tag, idx, l), fr[idx][l],
          (l == 0 || mm) ? exp_word(smp(src, l, 1), slot) : 32'h0);
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 mclk", mclk_o, 0);
    chk("R1 bclk", bclk_o, 0);
    chk("R1 lrclk", lrclk_o, 1);
    chk("R1 sd", sd_o, 0);
    chk("R1 ready", smp_ready, 1);
    chk("R1 underrun", underrun, 0);
  endtask

  task automatic t_dividers();
    int c;
    do_reset(8'd2, 8'd3, 1'b0, 2'd0, 1'b0);
    meas(1'b0, c); chk("R2 mclk period half=2", c, 4);
    meas(1'b1, c); chk("R3 bclk period half=3", c, 24);
    do_reset(8'd0, 8'd0, 1'b0, 2'd0, 1'b0);
    meas(1'b0, c); chk("R2 mclk period half=0", c, 2);
    meas(1'b1, c); chk("R3 bclk period half=0", c, 4);
    chk("R3 bclk edges on mclk rise", align_err, 0);
  endtask

  task automatic t_stereo_underrun();
    do_reset(8'd1, 8'd1, 1'b0, 2'd0, 1'b1);
    push(1);
    chk("R7 ready low while word waits", smp_ready, 0);
    push(2); push(3);
    wait_fc(3);
    chk("R10 no underrun while fed", underrun, 0);
    wait_fc(5);
    for (int i = 0; i < 4; i++) chk_frame("R8 R6 R5 stereo16", i, i, 16, 1'b0);
    chk_frame("R10 repeat", 4, 3, 16, 1'b0);
    chk("R10 underrun set", underrun, 1);
    @(negedge clk); underrun_clr = 1'b1;
    @(negedge clk); underrun_clr = 1'b0;
    chk("R10 underrun cleared", underrun, 0);
  endtask

  task automatic t_multi32();
    do_reset(8'd1, 8'd1, 1'b1, 2'd2, 1'b1);
    push(1); push(2);
    wait_fc(3);
    for (int i = 0; i < 3; i++) chk_frame("R9 R6 multi32", i, i, 32, 1'b1);
  endtask

  task automatic t_midframe_change();
    do_reset(8'd1, 8'd1, 1'b1, 2'd1, 1'b1);
    push(1); push(2);
    // frame 1 is now in flight; change both settings mid-frame
    slot_sel = 2'd0; multi_mode = 1'b0;
    push(3);
    wait_fc(4);
    chk_frame("R11 R5 multi24", 0, 0, 24, 1'b1);
    chk_frame("R11 frame kept old format", 1, 1, 24, 1'b1);
    chk_frame("R11 new format", 2, 2, 16, 1'b0);
    chk_frame("R11 R8 stereo16", 3, 3, 16, 1'b0);
  endtask

  initial begin
    t_reset();
    t_dividers();
    t_stereo_underrun();
    t_multi32();
    t_midframe_change();
    chk("R4 lrclk/sd change only on bclk fall", fmt_err, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule